// File: doc/BRIEF.md
# Interrupt Source Routing Multiplexer

This block sits in front of a CPU interrupt controller. It takes sixteen event sources and steers them onto the twelve maskable CPU interrupt lines, numbered 4 through 15. Sources 0 to 3 and 8 to 15 arrive as single-cycle pulses from peripherals: host port, timers, memory refresh, DMA channels and serial-port transmit and receive. Sources 4 to 7 are external pins. The block turns each pin into an edge event itself.

Each CPU line has a 4-bit selector, and the selector holds the number of the source that drives the line. The selectors are packed into two 32-bit words. A third word sets, for each external pin, which edge counts as an event on the CPU path. A second, unswitched rising-edge event for each pin goes out for DMA use.

Software programs the block through a plain write strobe with an address and data. Reads are combinational on the same address. Latching, enabling and vectoring stay in the downstream controller.

Top module: `irq_route_mux`

## Requirements
- R1: After reset, line n selects source n for every n from 4 to 15, the polarity word reads 0, and every event output is 0.
- R2: Offset 0x4 holds the selectors for lines 4..9 and offset 0x0 holds those for lines 10..15. Within each word the six fields, lowest line first, sit at bits 3:0, 8:5, 13:10, 19:16, 24:21 and 29:26. A write updates the fields, and a read returns them combinationally.
- R3: Bits 4, 9, 14, 15, 20, 25, 30 and 31 of both selector words read 0 whatever was written. Bits 31:4 of the polarity word (offset 0x8) read 0.
- R4: A write to any other offset changes no stored state, and a read of such an offset returns 0.
- R5: A line's event output is high one clock after its selected source's event, and low otherwise.
- R6: With polarity bit k set to 0, a low-to-high transition on pin k is the event for source 4+k. A high-to-low transition gives no event.
- R7: With polarity bit k set to 1, only a high-to-low transition on pin k is the event for source 4+k.
- R8: The DMA event for pin k pulses one clock after every rising edge of that pin, whatever the polarity setting.
- R9: All lines that select the same source pulse in the same cycle.
- R10: Writing 4'b0101 into the line 12 field (offset 0x0, bits 13:10) routes pin 1, which is source 5, onto line 12 (output bit 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational readback of cfg_addr |
| periph_evt_i | input | 12 | Pulses for sources 0..3 (bits 3:0) and sources 8..15 (bits 11:4) |
| ext_pin_i | input | 4 | External pin levels; bit k is source 4+k |
| cpu_line_evt_o | output | 12 | Event pulse per CPU line; bit i is line 4+i |
| dma_pin_evt_o | output | 4 | Rising-edge pulse per pin, independent of polarity |

## Verification
The bench rotates all twelve selectors through sixteen arrangements. In each arrangement it fires every source and compares the full line vector with a model. This catches a field decoded from the wrong bit position or the wrong word, and an off-by-one source index. On the external pins it raises and then lowers each pin under both polarity settings. A swapped or ignored polarity bit therefore shows up as an event on the wrong edge, and a polarity bit leaking into the DMA path shows up as a missing or misplaced DMA pulse. It also writes all ones to every word and writes to an unmapped offset. These steps expose unused bits that store data and decode that aliases onto real registers.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SRC_N       = 16;
  localparam int SEL_W       = 4;
  localparam int LINE_N      = 12;
  localparam int LINE_BASE   = 4;
  localparam int EXT_N       = 4;
  localparam int EXT_BASE    = 4;
  localparam int PERIPH_N    = SRC_N - EXT_N;
  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 4;
  localparam int FIELDS_WORD = LINE_N / 2;

  localparam logic [ADDR_W-1:0] OFF_SEL_HI = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_SEL_LO = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_POL    = 4'h8;

  // fields advance by five bits, with one extra gap bit after the third
  function automatic int field_lsb(input int j);
    return j * (SEL_W + 1) + ((j >= FIELDS_WORD / 2) ? 1 : 0);
  endfunction

  function automatic logic [WORD_W-1:0] sel_used_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int j = 0; j < FIELDS_WORD; j++) m[field_lsb(j) +: SEL_W] = '1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] SEL_USED = sel_used_mask();

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
  import irq_route_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [LINE_N-1:0][SEL_W-1:0]  sel_o,
  output logic [EXT_N-1:0]              pol_o,
  output logic [WORD_W-1:0]             rdata_o
);
  logic [LINE_N-1:0][SEL_W-1:0] sel_q;
  logic [EXT_N-1:0]             pol_q;
  logic [WORD_W-1:0]            lo_word, hi_word;
  logic                         unused_wbits;

  assign unused_wbits = ^(wdata_i & ~SEL_USED & ~WORD_W'({EXT_N{1'b1}}));

  for (genvar gi = 0; gi < LINE_N; gi++) begin : g_field
    localparam int J = gi % FIELDS_WORD;
    localparam int LSB = field_lsb(J);
    localparam logic [ADDR_W-1:0] OFF = (gi < FIELDS_WORD) ? OFF_SEL_LO : OFF_SEL_HI;
    always_ff @(posedge clk) begin
      if (!rst_n)                    sel_q[gi] <= SEL_W'(LINE_BASE + gi);
      else if (we_i && addr_i == OFF) sel_q[gi] <= wdata_i[LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          pol_q <= '0;
    else if (we_i && addr_i == OFF_POL)  pol_q <= wdata_i[EXT_N-1:0];
  end

  always_comb begin
    lo_word = '0;
    hi_word = '0;
    for (int j = 0; j < FIELDS_WORD; j++) begin
      lo_word[field_lsb(j) +: SEL_W] = sel_q[j];
      hi_word[field_lsb(j) +: SEL_W] = sel_q[j + FIELDS_WORD];
    end
  end

  always_comb begin
    case (addr_i)
      OFF_SEL_HI: rdata_o = hi_word;
      OFF_SEL_LO: rdata_o = lo_word;
      OFF_POL:    rdata_o = WORD_W'(pol_q);
      default:    rdata_o = '0;
    endcase
  end

  assign sel_o = sel_q;
  assign pol_o = pol_q;

  // R4: state only moves on a write strobe
  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(sel_q) && $stable(pol_q)));
  // R3: gap bits of selector words never read back set
  assert_gap_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == OFF_SEL_HI || addr_i == OFF_SEL_LO) |-> ((rdata_o & ~SEL_USED) == '0));
  // R3: polarity word upper bits read zero
  assert_pol_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == OFF_POL) |-> (rdata_o[WORD_W-1:EXT_N] == '0));
endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic falling_i,
  output logic cpu_edge_o,
  output logic raw_edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_i;
  end

  assign raw_edge_o = pin_i & ~prev_q;
  assign cpu_edge_o = falling_i ? (prev_q & ~pin_i) : raw_edge_o;

  // R7: an inverted pin never reports both paths on the same transition
  assert_inverted_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    falling_i |-> !(cpu_edge_o && raw_edge_o));
  // R6: a pin in default polarity gives the same event on both paths
  assert_default_matches_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !falling_i |-> (cpu_edge_o == raw_edge_o));
endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux
  import irq_route_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_N-1:0]              src_i,
  input  logic [LINE_N-1:0][SEL_W-1:0]  sel_i,
  output logic [LINE_N-1:0]             evt_o
);
  logic [LINE_N-1:0] evt_q;

  for (genvar gi = 0; gi < LINE_N; gi++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[gi] <= 1'b0;
      else        evt_q[gi] <= src_i[sel_i[gi]];
    end

    // R5: a line only pulses after some source fired
    assert_evt_needs_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q[gi] |-> ($past(src_i) != '0));

    if (gi > 0) begin : g_share
      // R9: lines sharing a selector pulse together
      assert_shared_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_i[gi] == sel_i[0]) |-> (evt_q[gi] == evt_q[0]));
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
  import irq_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    cfg_rdata,
  input  logic [PERIPH_N-1:0]  periph_evt_i,
  input  logic [EXT_N-1:0]     ext_pin_i,
  output logic [LINE_N-1:0]    cpu_line_evt_o,
  output logic [EXT_N-1:0]     dma_pin_evt_o
);
  logic [LINE_N-1:0][SEL_W-1:0] sel;
  logic [EXT_N-1:0]             pol;
  logic [EXT_N-1:0]             cpu_edge, raw_edge;
  logic [EXT_N-1:0]             dma_q;
  logic [SRC_N-1:0]             src_vec;

  irq_sel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .sel_o(sel), .pol_o(pol), .rdata_o(cfg_rdata)
  );

  for (genvar gk = 0; gk < EXT_N; gk++) begin : g_pin
    irq_pin_edge u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i[gk]), .falling_i(pol[gk]),
      .cpu_edge_o(cpu_edge[gk]), .raw_edge_o(raw_edge[gk])
    );

    // R8: DMA pulse only follows a pin that was high
    assert_dma_after_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_q[gk] |-> $past(ext_pin_i[gk]));
  end

  always_comb begin
    src_vec = {periph_evt_i[PERIPH_N-1:EXT_BASE], cpu_edge, periph_evt_i[EXT_BASE-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dma_q <= '0;
    else        dma_q <= raw_edge;
  end

  irq_line_mux u_mux (
    .clk(clk), .rst_n(rst_n), .src_i(src_vec), .sel_i(sel), .evt_o(cpu_line_evt_o)
  );

  assign dma_pin_evt_o = dma_q;
endmodule

// File: tb/sim_irq_route_mux.sv
module sim_irq_route_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [11:0] periph_evt_i = '0;
  logic [3:0]  ext_pin_i = '0;
  logic [11:0] cpu_line_evt_o;
  logic [3:0]  dma_pin_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int sel_m [12];
  logic [3:0] pol_m;

  always #5 clk = ~clk;

  irq_route_mux u0 (.*);

  function automatic int lsb_of(int j);
    return j * 5 + ((j > 2) ? 1 : 0);
  endfunction

  function automatic logic [31:0] word_of(int first);
    logic [31:0] w = '0;
    for (int j = 0; j < 6; j++) w = w | (32'(sel_m[first + j] & 15) << lsb_of(j));
    return w;
  endfunction

  function automatic logic [11:0] exp_lines(int s);
    logic [11:0] v = '0;
    for (int i = 0; i < 12; i++) v[i] = (sel_m[i] == s);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic program_sel();
    wr(4'h0, word_of(6));
    wr(4'h4, word_of(0));
  endtask

  // fire a peripheral pulse or a full pin cycle (rise then fall)
  task automatic fire(int s, string tag);
    int k;
    logic [11:0] e_rise, e_fall;
    logic [3:0]  d_rise;
    k = s - 4;
    @(negedge clk);
    if (s >= 4 && s < 8) begin
      ext_pin_i[k] = 1'b1;
      e_rise = pol_m[k] ? 12'h0 : exp_lines(s);
      e_fall = pol_m[k] ? exp_lines(s) : 12'h0;
      d_rise = 4'(1 << k);
    end else begin
      periph_evt_i[(s < 4) ? s : s - 4] = 1'b1;
      e_rise = exp_lines(s);
      e_fall = 12'h0;
      d_rise = 4'h0;
    end
    @(negedge clk);
    chk({tag, " lines after rise/pulse"}, 32'(cpu_line_evt_o), 32'(e_rise));
    chk({tag, " dma after rise R8"}, 32'(dma_pin_evt_o), 32'(d_rise));
    periph_evt_i = '0;
    ext_pin_i = '0;
    @(negedge clk);
    chk({tag, " lines after fall/idle"}, 32'(cpu_line_evt_o), 32'(e_fall));
    chk({tag, " dma after fall R8"}, 32'(dma_pin_evt_o), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pol_m = '0;
    for (int i = 0; i < 12; i++) sel_m[i] = i + 4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd("R1 reset hi word", 4'h0, word_of(6));
    rd("R1 reset lo word", 4'h4, word_of(0));
    rd("R1 reset polarity", 4'h8, 32'h0);
    chk("R1 reset lines", 32'(cpu_line_evt_o), 32'h0);
    chk("R1 reset dma", 32'(dma_pin_evt_o), 32'h0);
    for (int s = 0; s < 16; s++) fire(s, "R1 default route");

    // R2 R5 R6: rotate every selector across all sources
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < 12; i++) sel_m[i] = (i + 4 + r * 5) % 16;
      program_sel();
      rd("R2 hi readback", 4'h0, word_of(6));
      rd("R2 lo readback", 4'h4, word_of(0));
      for (int s = 0; s < 16; s++) fire(s, "R5 R6 sweep");
    end

    // R9: every line on one pin
    for (int i = 0; i < 12; i++) sel_m[i] = 6;
    program_sel();
    fire(6, "R9 all lines share pin 2");
    for (int i = 0; i < 12; i++) sel_m[i] = (i % 2 == 0) ? 9 : 13;
    program_sel();
    fire(9, "R9 even lines share 9");
    fire(13, "R9 odd lines share 13");

    // R10: line 12 field gets 5
    for (int i = 0; i < 12; i++) sel_m[i] = 0;
    program_sel();
    wr(4'h0, 32'(5) << 10);
    sel_m[8] = 5;
    rd("R10 hi readback", 4'h0, word_of(6));
    fire(5, "R10 pin 1 onto line 12");
    chk("R10 model bit 8", 32'(exp_lines(5)), 32'h100);

    // R7 R8: polarity inverted, then mixed
    for (int i = 0; i < 12; i++) sel_m[i] = 4 + (i % 4);
    program_sel();
    pol_m = 4'hF;
    wr(4'h8, 32'hF);
    rd("R7 polarity readback", 4'h8, 32'hF);
    for (int s = 4; s < 8; s++) fire(s, "R7 falling edge");
    pol_m = 4'b0101;
    wr(4'h8, 32'h5);
    for (int s = 4; s < 8; s++) fire(s, "R6 R7 mixed polarity");

    // R3: all-ones writes
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    for (int i = 0; i < 12; i++) sel_m[i] = 15;
    pol_m = 4'hF;
    rd("R3 hi gap bits", 4'h0, word_of(6));
    rd("R3 lo gap bits", 4'h4, word_of(0));
    rd("R3 pol upper bits", 4'h8, 32'hF);

    // R4: unmapped offset
    wr(4'hC, 32'h0);
    wr(4'h2, 32'h0);
    rd("R4 unmapped read", 4'hC, 32'h0);
    rd("R4 hi unchanged", 4'h0, word_of(6));
    rd("R4 lo unchanged", 4'h4, word_of(0));
    rd("R4 pol unchanged", 4'h8, 32'hF);
    fire(15, "R4 routing unchanged");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule